// File: doc/BRIEF.md
# Binary Cell Mismatch Calibration Engine

This block trims the binary-weighted cells of a segmented current-steering converter. Each calibration unit in the array is measured once by a slow low-resolution converter, and the resulting 5-bit code is written into the engine through a simple address/data port. Each binary cell owns a private pool of identical units, twice as many as it needs. The engine picks which units in each pool are switched on, so that the cell's summed code lands as close as possible to its ideal weight.

The ideal weight of cell i is the mean code of every calibration unit in the array, scaled by 2^i. The engine never divides to form this mean. It compares `UNITS * S` against `2^i * (sum of all codes)`, which keeps the result exact. For each cell the pool is ranked by code and the largest 2^i units are enabled first. Rank-ordered swaps then move the sum downward while each swap still cuts the error. The result is a per-cell enable mask, the total code of all enabled binary units, and a reference for the unary stage. That reference is the binary total plus the code of one extra reference unit.

Top module: `bin_cell_calibrator`

## Requirements
- R1: After reset `done` is 0, `maskFlat`, `binTotal` and `unaryRef` are 0, and every stored code is 0.
- R2: A write with `wrValid` high stores `wrData` at `wrAddr` when the engine is idle, including in the same cycle that `start` is accepted; that code is then used by the run. Addresses 0 to UNITS-1 are calibration units and address UNITS (14 for three cells) is the reference unit.
- R3: Writes presented while a run is in progress are ignored; the stored code is unchanged for that run and for later runs.
- R4: Cell i owns 2^(i+1) units at addresses 2^(i+1)-2 upward. Mask bit b of field `maskFlat[i*POOL_MAX +: POOL_MAX]` enables unit base+b. Bits at or above the pool size are 0.
- R5: Every completed mask of cell i has exactly 2^i bits set.
- R6: The pool is ranked by descending code and the top 2^i are enabled first. Swap j exchanges rank j for rank 2^i+j. A swap is taken only when it strictly reduces |UNITS*S - 2^i*SumAll|, and the first swap that fails ends the search.
- R7: `binTotal` equals the sum of the codes of all enabled units over all cells.
- R8: `unaryRef` equals `binTotal` plus the code of the reference unit.
- R9: `done` falls in the cycle after an accepted `start`. It rises once all cells are finished and holds, with outputs stable, until the next `start`. A `start` during a run is ignored.
- R10: The target mean is taken over the UNITS calibration units only; the reference unit does not enter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Code write strobe |
| wrAddr | input | ADDR_W | Unit address for the write |
| wrData | input | CODE_W | Measured unit code |
| start | input | 1 | Begin a calibration run |
| done | output | 1 | Results valid |
| maskFlat | output | NUM_CELLS*POOL_MAX | Per-cell enable masks, cell i in field i |
| binTotal | output | TOT_W | Sum of enabled binary unit codes |
| unaryRef | output | TOT_W+1 | Reference code for the unary stage |

## Verification
Two functions of the engine can land on the same edge. One is a code write, which only the idle state accepts. The other is the `start` strobe, which ends the idle state. The bench raises both in one cycle with a new code, and checks that every mask, the total and the reference follow a model that holds the new value. It then writes a wild code several cycles into a run and raises a second `start` mid-run. It judges the outcome by the results of that run and of a fresh run, which must both match a model that never saw the wild code.

// File: rtl/calib_pkg.sv
package calib_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SORT,
    ST_SEED,
    ST_WALK,
    ST_COMMIT,
    ST_FINISH
  } calState_t;

  // strobes from control into datapath
  typedef struct packed {
    logic clearRun;
    logic latchPool;
    logic sortStep;
    logic seed;
    logic takeSwap;
    logic commit;
    logic finish;
  } calStrobe_t;

endpackage

// File: rtl/calib_dp.sv
module calib_dp
  import calib_pkg::*;
#(
  parameter int NUM_CELLS = 3,
  parameter int CODE_W    = 5,
  localparam int POOL_MAX  = 1 << NUM_CELLS,
  localparam int UNITS     = (2 << NUM_CELLS) - 2,
  localparam int MEM_DEPTH = UNITS + 1,
  localparam int ADDR_W    = $clog2(MEM_DEPTH),
  localparam int IDX_W     = NUM_CELLS,
  localparam int CELL_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int TOT_W     = CODE_W + NUM_CELLS,
  localparam int SUM_W     = CODE_W + NUM_CELLS + 1,
  localparam int ERR_W     = CODE_W + 2 * NUM_CELLS + 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrValid,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [CODE_W-1:0]             wrData,
  input  logic                          acceptWr,
  input  calStrobe_t                    strb,
  input  logic [CELL_W-1:0]             cellIdx,
  input  logic                          sortPhase,
  output logic                          swapGood,
  output logic [NUM_CELLS*POOL_MAX-1:0] maskFlat,
  output logic [TOT_W-1:0]              binTotal,
  output logic [TOT_W:0]                unaryRef
);

  logic [CODE_W-1:0] codeMem  [MEM_DEPTH];
  logic [CODE_W-1:0] sortCode [POOL_MAX];
  logic [IDX_W-1:0]  sortIdx  [POOL_MAX];
  logic [SUM_W-1:0]  sumAll, grandSum;
  logic [TOT_W-1:0]  curSum, nextSum, seedSum;
  logic [IDX_W:0]    swapPos;
  logic [POOL_MAX-1:0] cellMask;
  logic [ERR_W-1:0]  target, scaledCur, scaledNext, errCur, errNext;
  logic [CODE_W-1:0] outCode, inCode;
  int poolSizeI, keepKI, swapPosI, poolBaseI, inPosI;

  // code storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < MEM_DEPTH; u++) codeMem[u] <= '0;
    end else if (wrValid && acceptWr && (int'(wrAddr) < MEM_DEPTH)) begin
      codeMem[wrAddr] <= wrData;
    end
  end

  always_comb begin
    grandSum = '0;
    for (int u = 0; u < UNITS; u++) grandSum = grandSum + SUM_W'(codeMem[u]);
  end

  always_comb begin
    keepKI    = 1 << int'(cellIdx);
    poolSizeI = 2 * keepKI;
    poolBaseI = poolSizeI - 2;
    swapPosI  = int'(swapPos);
    inPosI    = swapPosI + keepKI;
    if (inPosI > POOL_MAX - 1) inPosI = POOL_MAX - 1;
  end

  // pool load and odd-even transposition ranking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < POOL_MAX; p++) begin
        sortCode[p] <= '0;
        sortIdx[p]  <= '0;
      end
    end else if (strb.latchPool) begin
      for (int p = 0; p < POOL_MAX; p++) begin
        sortCode[p] <= (p < poolSizeI) ? codeMem[poolBaseI + p] : '0;
        sortIdx[p]  <= IDX_W'(p);
      end
    end else if (strb.sortStep) begin
      for (int p = 0; p < POOL_MAX - 1; p++) begin
        if (((p % 2) == int'(sortPhase)) && (p + 1 < poolSizeI) &&
            (sortCode[p] < sortCode[p+1])) begin
          sortCode[p]   <= sortCode[p+1];
          sortCode[p+1] <= sortCode[p];
          sortIdx[p]    <= sortIdx[p+1];
          sortIdx[p+1]  <= sortIdx[p];
        end
      end
    end
  end

  always_comb begin
    seedSum = '0;
    for (int p = 0; p < POOL_MAX; p++)
      if (p < keepKI) seedSum = seedSum + TOT_W'(sortCode[p]);
  end

  // error against scaled mean, no division
  always_comb begin
    outCode    = sortCode[swapPos[IDX_W-1:0]];
    inCode     = sortCode[inPosI];
    nextSum    = curSum - TOT_W'(outCode) + TOT_W'(inCode);
    target     = ERR_W'(sumAll) << cellIdx;
    scaledCur  = ERR_W'(curSum) * ERR_W'(UNITS);
    scaledNext = ERR_W'(nextSum) * ERR_W'(UNITS);
    errCur     = (scaledCur  >= target) ? scaledCur  - target : target - scaledCur;
    errNext    = (scaledNext >= target) ? scaledNext - target : target - scaledNext;
    swapGood   = (swapPosI < keepKI) && (errNext < errCur);
  end

  always_comb begin
    cellMask = '0;
    for (int p = 0; p < POOL_MAX; p++)
      if ((p >= swapPosI) && (p < swapPosI + keepKI)) cellMask[sortIdx[p]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumAll   <= '0;
      curSum   <= '0;
      swapPos  <= '0;
      maskFlat <= '0;
      binTotal <= '0;
      unaryRef <= '0;
    end else begin
      if (strb.clearRun) begin
        maskFlat <= '0;
        binTotal <= '0;
      end
      if (strb.latchPool) sumAll <= grandSum;
      if (strb.seed) begin
        curSum  <= seedSum;
        swapPos <= '0;
      end
      if (strb.takeSwap) begin
        curSum  <= nextSum;
        swapPos <= swapPos + 1'b1;
      end
      if (strb.commit) begin
        maskFlat[int'(cellIdx)*POOL_MAX +: POOL_MAX] <= cellMask;
        binTotal <= binTotal + curSum;
      end
      if (strb.finish) unaryRef <= (TOT_W+1)'(binTotal) + (TOT_W+1)'(codeMem[UNITS]);
    end
  end

endmodule

// File: rtl/calib_ctl.sv
module calib_ctl
  import calib_pkg::*;
#(
  parameter int NUM_CELLS = 3,
  localparam int POOL_MAX = 1 << NUM_CELLS,
  localparam int CELL_W   = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int SCNT_W   = $clog2(POOL_MAX) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              swapGood,
  output calStrobe_t        strb,
  output logic [CELL_W-1:0] cellIdx,
  output logic              sortPhase,
  output logic              acceptWr,
  output logic              done
);

  calState_t state;
  logic [SCNT_W-1:0] sortCnt;

  always_comb begin
    strb           = '0;
    strb.clearRun  = (state == ST_IDLE) && start;
    strb.latchPool = (state == ST_LOAD);
    strb.sortStep  = (state == ST_SORT);
    strb.seed      = (state == ST_SEED);
    strb.takeSwap  = (state == ST_WALK) && swapGood;
    strb.commit    = (state == ST_COMMIT);
    strb.finish    = (state == ST_FINISH);
    sortPhase      = sortCnt[0];
    acceptWr       = (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sortCnt <= '0;
      cellIdx <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          done    <= 1'b0;
          cellIdx <= '0;
          state   <= ST_LOAD;
        end
        ST_LOAD: begin
          sortCnt <= '0;
          state   <= ST_SORT;
        end
        ST_SORT: begin
          if (int'(sortCnt) == POOL_MAX - 1) state <= ST_SEED;
          else sortCnt <= sortCnt + 1'b1;
        end
        ST_SEED: state <= ST_WALK;
        ST_WALK: if (!swapGood) state <= ST_COMMIT;
        ST_COMMIT: begin
          if (int'(cellIdx) == NUM_CELLS - 1) state <= ST_FINISH;
          else begin
            cellIdx <= cellIdx + 1'b1;
            state   <= ST_LOAD;
          end
        end
        ST_FINISH: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bin_cell_calibrator.sv
module bin_cell_calibrator
  import calib_pkg::*;
#(
  parameter int NUM_CELLS = 3,
  parameter int CODE_W    = 5,
  localparam int POOL_MAX  = 1 << NUM_CELLS,
  localparam int MEM_DEPTH = (2 << NUM_CELLS) - 1,
  localparam int ADDR_W    = $clog2(MEM_DEPTH),
  localparam int CELL_W    = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1,
  localparam int TOT_W     = CODE_W + NUM_CELLS
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrValid,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [CODE_W-1:0]             wrData,
  input  logic                          start,
  output logic                          done,
  output logic [NUM_CELLS*POOL_MAX-1:0] maskFlat,
  output logic [TOT_W-1:0]              binTotal,
  output logic [TOT_W:0]                unaryRef
);

  calStrobe_t        strb;
  logic [CELL_W-1:0] cellIdx;
  logic              sortPhase, swapGood, acceptWr;

  calib_ctl #(.NUM_CELLS(NUM_CELLS)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .swapGood(swapGood),
    .strb(strb), .cellIdx(cellIdx), .sortPhase(sortPhase),
    .acceptWr(acceptWr), .done(done)
  );

  calib_dp #(.NUM_CELLS(NUM_CELLS), .CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .acceptWr(acceptWr), .strb(strb), .cellIdx(cellIdx),
    .sortPhase(sortPhase), .swapGood(swapGood), .maskFlat(maskFlat),
    .binTotal(binTotal), .unaryRef(unaryRef)
  );

endmodule

// File: rtl/bin_cell_calibrator_chk.sv
module bin_cell_calibrator_chk #(
  parameter int NUM_CELLS = 3,
  parameter int CODE_W    = 5,
  localparam int POOL_MAX = 1 << NUM_CELLS,
  localparam int TOT_W    = CODE_W + NUM_CELLS
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          start,
  input logic                          done,
  input logic [NUM_CELLS*POOL_MAX-1:0] maskFlat,
  input logic [TOT_W-1:0]              binTotal,
  input logic [TOT_W:0]                unaryRef
);

  assert_done_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done);

  assert_done_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_total_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> ($stable(binTotal) && $stable(maskFlat)));

  assert_ref_offset_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((unaryRef >= (TOT_W+1)'(binTotal)) &&
              (unaryRef - (TOT_W+1)'(binTotal) <= (TOT_W+1)'((1 << CODE_W) - 1))));

  for (genvar i = 0; i < NUM_CELLS; i++) begin : gCell
    localparam logic [POOL_MAX-1:0] POOL_BITS = POOL_MAX'((64'd1 << (2 << i)) - 1);
    assert_popcount_R5: assert property (@(posedge clk) disable iff (!rstN)
      done |-> ($countones(maskFlat[i*POOL_MAX +: POOL_MAX]) == (1 << i)));
    assert_pool_bits_R4: assert property (@(posedge clk) disable iff (!rstN)
      done |-> ((maskFlat[i*POOL_MAX +: POOL_MAX] & ~POOL_BITS) == '0));
  end

endmodule

bind bin_cell_calibrator bin_cell_calibrator_chk #(
  .NUM_CELLS(NUM_CELLS), .CODE_W(CODE_W)
) uChk (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .maskFlat(maskFlat), .binTotal(binTotal), .unaryRef(unaryRef)
);

// File: tb/sim_bin_cell_calibrator.sv
module sim_bin_cell_calibrator;
  localparam int NC = 3;
  localparam int CW = 5;
  localparam int PM = 8;
  localparam int UN = 14;
  localparam int MD = 15;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, wrValid, start, done;
  logic [3:0] wrAddr;
  logic [CW-1:0] wrData;
  logic [NC*PM-1:0] maskFlat;
  logic [7:0] binTotal;
  logic [8:0] unaryRef;

  int mdl [MD];
  int expSum [NC];
  int checks = 0;
  int fails = 0;

  bin_cell_calibrator #(.NUM_CELLS(NC), .CODE_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .start(start), .done(done), .maskFlat(maskFlat),
    .binTotal(binTotal), .unaryRef(unaryRef)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int absI(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // expected selection built from the ranking and swap rule
  task automatic computeModel();
    int sumAll;
    sumAll = 0;
    for (int u = 0; u < UN; u++) sumAll += mdl[u];
    for (int i = 0; i < NC; i++) begin
      int arr [PM];
      int k, p, s, j, tgt, sn, tmp;
      k = 1 << i;
      p = 2 * k;
      for (int b = 0; b < PM; b++) arr[b] = (b < p) ? mdl[p - 2 + b] : 0;
      for (int a = 0; a < p; a++)
        for (int b = 0; b < p - 1; b++)
          if (arr[b] < arr[b+1]) begin
            tmp = arr[b]; arr[b] = arr[b+1]; arr[b+1] = tmp;
          end
      s = 0;
      for (int b = 0; b < k; b++) s += arr[b];
      tgt = sumAll << i;
      j = 0;
      while (j < k) begin
        sn = s - arr[j] + arr[k + j];
        if (absI(UN * sn - tgt) < absI(UN * s - tgt)) begin
          s = sn;
          j++;
        end else break;
      end
      expSum[i] = s;
    end
  endtask

  task automatic writeCode(input int a, input int v, input bit track);
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = 4'(a);
    wrData  = CW'(v);
    @(negedge clk);
    wrValid = 1'b0;
    if (track && a < MD) mdl[a] = v;
  endtask

  task automatic startRun(input bit withWr, input int a, input int v);
    @(negedge clk);
    start = 1'b1;
    if (withWr) begin
      wrValid = 1'b1;
      wrAddr  = 4'(a);
      wrData  = CW'(v);
    end
    @(negedge clk);
    start   = 1'b0;
    wrValid = 1'b0;
    if (withWr) mdl[a] = v;
    check(done == 1'b0, "R9 done low after start", int'(done), 0);
  endtask

  task automatic waitDone();
    int n;
    n = 0;
    while (!done && n < 1000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1, "R9 done raised at end of run", int'(done), 1);
  endtask

  task automatic checkResults(input string tag);
    int total;
    computeModel();
    total = 0;
    for (int i = 0; i < NC; i++) begin
      logic [PM-1:0] m;
      int pop, sum, p;
      m = maskFlat[i*PM +: PM];
      p = 2 << i;
      pop = 0;
      sum = 0;
      for (int b = 0; b < PM; b++)
        if (m[b]) begin
          pop++;
          if (b < p) sum += mdl[p - 2 + b];
        end
      check(pop == (1 << i), {tag, " R5 popcount"}, pop, 1 << i);
      if (p < PM) check((m >> p) == 0, {tag, " R4 bits outside pool"}, int'(m >> p), 0);
      check(sum == expSum[i], {tag, " R6 R10 selected code sum"}, sum, expSum[i]);
      total += expSum[i];
    end
    check(int'(binTotal) == total, {tag, " R7 binary total"}, int'(binTotal), total);
    check(int'(unaryRef) == total + mdl[UN], {tag, " R8 unary reference"},
          int'(unaryRef), total + mdl[UN]);
  endtask

  task automatic loadAll(input int kind);
    for (int a = 0; a < MD; a++) begin
      int v;
      case (kind)
        1: v = 16;
        2: v = (a * 2) % 32;
        3: v = (a % 2) ? 31 : 0;
        4: v = 31;
        5: v = 31 - 2 * a;
        6: v = (a == UN) ? 31 : (a % 3);
        default: v = int'($urandom % 32);
      endcase
      writeCode(a, v, 1'b1);
    end
  endtask

  initial begin
    #1ms;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrValid = 1'b0; start = 1'b0; wrAddr = '0; wrData = '0;
    for (int a = 0; a < MD; a++) mdl[a] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R1 reset done", int'(done), 0);
    check(maskFlat == '0, "R1 reset masks", int'(maskFlat), 0);
    check(binTotal == '0, "R1 reset total", int'(binTotal), 0);
    check(unaryRef == '0, "R1 reset reference", int'(unaryRef), 0);

    // R1: stored codes reset to zero, run on them
    startRun(1'b0, 0, 0);
    waitDone();
    checkResults("R1 zero codes");

    for (int kind = 1; kind <= 6; kind++) begin
      loadAll(kind);
      startRun(1'b0, 0, 0);
      waitDone();
      checkResults("pattern");
    end

    for (int r = 0; r < 60; r++) begin
      loadAll(0);
      startRun(1'b0, 0, 0);
      waitDone();
      checkResults("random");
    end

    // R2: write in the same cycle as start is used by the run
    loadAll(0);
    startRun(1'b1, 3, 31);
    waitDone();
    checkResults("R2 write with start");
    startRun(1'b1, UN, 7);
    waitDone();
    checkResults("R2 reference unit write with start");

    // R3 and R9: write and second start during a run are ignored
    loadAll(0);
    startRun(1'b0, 0, 0);
    repeat (2) @(negedge clk);
    wrValid = 1'b1; wrAddr = 4'd2; wrData = CW'((mdl[2] + 17) % 32);
    start = 1'b1;
    @(negedge clk);
    wrValid = 1'b0; start = 1'b0;
    check(done == 1'b0, "R9 start during run ignored", int'(done), 0);
    waitDone();
    checkResults("R3 busy write");
    startRun(1'b0, 0, 0);
    waitDone();
    checkResults("R3 code unchanged later");

    // R9: outputs hold while idle
    repeat (5) @(negedge clk);
    check(done == 1'b1, "R9 done holds", int'(done), 1);
    checkResults("R9 hold");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule